// File: doc/BRIEF.md
# Double-Buffered Gate Schedule Engine

This block drives the transmit gates of one Ethernet port that carries eight traffic priorities. A host loads gate commands into a small local RAM that is split into two banks. Each command names the set of priorities whose gates are open and how long that set stays in force. The duration is measured in transmit data units: one unit per byte at gigabit speed, or one unit per nibble at 10/100 speed. An external timer sends a cycle-start pulse. Each pulse restarts the schedule at command 0 of the bank in use.

The host writes a new schedule into the idle bank and then flips a bank-select input. The engine changes to that bank only when the next cycle-start pulse arrives, so a cycle never mixes commands from two schedules. The active-bank output lets the host see when the switch has happened. A command with zero duration closes the list. Its mask then holds until the next cycle start, which leaves the rest of the cycle to the priorities that have no time slot. Two sticky error flags report a cycle start that cut a command short and a list that ran off the end of its bank.

Top module: `gate_sched_engine`

## Requirements
- R1: A host write stores the 22-bit command on `host_wr_data` at `host_wr_addr`. Bit 6 of the address chooses the bank and bits 5:0 give the command index. In the command, bits 7:0 are the gate mask and bits 21:8 are the duration.
- R2: `cyc_start` is sampled high at a rising edge while the engine is enabled. The mask of command 0 of the bank chosen at that edge appears on `gate_mask` after the second rising edge that follows.
- R3: `active_bank` changes only at an enabled cycle start. At that point it takes the value of `bank_sel`.
- R4: With `link_gig`=1 only `byte_tick` pulses count toward the duration. With `link_gig`=0 only `nib_tick` pulses count. The other tick input has no effect.
- R5: A non-zero duration below 16 counts as 16 units.
- R6: A command with a zero duration ends the list. Its mask stays on `gate_mask` until the next cycle start, whatever ticks arrive.
- R7: When the effective duration of a command has been counted, the engine moves to the next command of the same bank and its mask appears on `gate_mask`.
- R8: While `one_bank`=1, a cycle start restarts the schedule in the current active bank and `active_bank` does not follow `bank_sel`.
- R9: The engine runs only while `glb_en` and `port_en` are both 1. In any other state, and after enable until the first cycle start, `gate_mask` is 8'hFF. Disabling the engine clears both error flags.
- R10: If the command at index 63 completes with a non-zero duration, `err_addr` is set and its mask is held until the next cycle start.
- R11: If a cycle start arrives while a command is still counting, `err_count` is set and the schedule restarts at command 0.
- R12: After reset, `gate_mask` is 8'hFF, `active_bank` is 0 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global schedule enable |
| port_en | input | 1 | Per-port schedule enable |
| link_gig | input | 1 | 1: durations count bytes; 0: durations count nibbles |
| byte_tick | input | 1 | One pulse per transmitted byte time |
| nib_tick | input | 1 | One pulse per transmitted nibble time |
| cyc_start | input | 1 | Cycle-start pulse from the external timer |
| host_wr_en | input | 1 | Command RAM write strobe |
| host_wr_addr | input | 7 | Bank (bit 6) and command index (bits 5:0) |
| host_wr_data | input | 22 | Command: duration in 21:8, gate mask in 7:0 |
| bank_sel | input | 1 | Bank the host wants used from the next cycle |
| one_bank | input | 1 | 1: bank swapping disabled |
| gate_mask | output | 8 | Per-priority transmit allow mask |
| active_bank | output | 1 | Bank currently in use |
| err_count | output | 1 | Sticky: cycle start cut a command short |
| err_addr | output | 1 | Sticky: list ran past the end of its bank |

## Verification
The assertions are checked on every clock. They cover the following: the active bank moves only at an enabled cycle start and never in one-bank mode; a cycle start always restarts at index 0; a start during counting raises the count error; a terminated list holds its mask; a disabled engine opens every gate. Some behaviour depends on the RAM contents and the tick stream, so only the bench scenarios can show it. This includes the exact mask sequence, the floor of 16 on short durations, the rejection of ticks of the wrong speed, the hold after the command at index 63 and the switch to a newly written bank. The bench runs each of these against schedules it computes itself.

// File: rtl/gse_pkg.sv
package gse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_HOLD
  } gse_state_e;
endpackage

// File: rtl/gse_cmd_ram.sv
module gse_cmd_ram #(
  parameter int AW = 7,
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gse_bank_ctrl.sv
module gse_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cyc_go,
  input  logic bank_sel,
  input  logic one_bank,
  output logic bank_next,
  output logic act_bank
);
  assign bank_next = one_bank ? act_bank : bank_sel;

  always_ff @(posedge clk) begin
    if (rst) act_bank <= 1'b0;
    else if (cyc_go) act_bank <= bank_next;
  end

  AST_BANK_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !cyc_go |=> $stable(act_bank)); // R3
  AST_ONE_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_go && one_bank) |=> $stable(act_bank)); // R8
endmodule

// File: rtl/gse_sequencer.sv
module gse_sequencer
  import gse_pkg::*;
#(
  parameter int MASK_W  = 8,
  parameter int CNT_W   = 14,
  parameter int IDX_W   = 6,
  parameter int MIN_CNT = 16,
  localparam int DW     = MASK_W + CNT_W,
  localparam int AW     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cyc_start,
  input  logic              unit_tick,
  input  logic              bank_next,
  input  logic              act_bank,
  input  logic [DW-1:0]     rd_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic [MASK_W-1:0] mask,
  output logic              err_count,
  output logic              err_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

  gse_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             cyc_go;
  logic             cmd_done;
  logic [CNT_W-1:0] q_dur;
  logic [MASK_W-1:0] q_mask;
  logic [CNT_W-1:0] q_eff;

  assign cyc_go   = en && cyc_start;
  assign cmd_done = (state == ST_RUN) && unit_tick && (cnt == ONE_C);
  assign q_mask   = rd_data[MASK_W-1:0];
  assign q_dur    = rd_data[DW-1:MASK_W];
  assign q_eff    = (q_dur < MIN_C) ? MIN_C : q_dur;

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    if (cyc_go) begin
      rd_en   = 1'b1;
      rd_addr = {bank_next, {IDX_W{1'b0}}};
    end else if (en && cmd_done && idx != LAST_IDX) begin
      rd_en   = 1'b1;
      rd_addr = {act_bank, idx + IDX_W'(1)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= ST_IDLE;
      mask      <= '1;
      idx       <= '0;
      cnt       <= '0;
      err_count <= 1'b0;
      err_addr  <= 1'b0;
    end else if (cyc_go) begin
      if (state == ST_RUN) err_count <= 1'b1;
      state <= ST_LOAD;
      idx   <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          mask <= q_mask;
          if (q_dur == '0) begin
            state <= ST_HOLD;
          end else begin
            cnt   <= q_eff;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cmd_done) begin
            if (idx == LAST_IDX) begin
              err_addr <= 1'b1;
              state    <= ST_HOLD;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_LOAD;
            end
          end else if (unit_tick) begin
            cnt <= cnt - ONE_C;
          end
        end
        default: ;
      endcase
    end
  end

  AST_OFF_ALL_OPEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> (mask == {MASK_W{1'b1}})); // R9
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    cyc_go |=> (idx == '0 && state == ST_LOAD)); // R2
  AST_CNT_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (cyc_go && state == ST_RUN) |=> err_count); // R11
  AST_HOLD_MASK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && en && !cyc_start) |=> $stable(mask)); // R6
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt != '0)); // R5
endmodule

// File: rtl/gate_sched_engine.sv
module gate_sched_engine #(
  parameter int MASK_W  = 8,
  parameter int CNT_W   = 14,
  parameter int IDX_W   = 6,
  parameter int MIN_CNT = 16,
  localparam int DW     = MASK_W + CNT_W,
  localparam int AW     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              port_en,
  input  logic              link_gig,
  input  logic              byte_tick,
  input  logic              nib_tick,
  input  logic              cyc_start,
  input  logic              host_wr_en,
  input  logic [AW-1:0]     host_wr_addr,
  input  logic [DW-1:0]     host_wr_data,
  input  logic              bank_sel,
  input  logic              one_bank,
  output logic [MASK_W-1:0] gate_mask,
  output logic              active_bank,
  output logic              err_count,
  output logic              err_addr
);
  logic          en;
  logic          unit_tick;
  logic          bank_next;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  assign en        = glb_en && port_en;
  assign unit_tick = link_gig ? byte_tick : nib_tick;

  gse_cmd_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .wr_en   (host_wr_en),
    .wr_addr (host_wr_addr),
    .wr_data (host_wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  gse_bank_ctrl u_bank (
    .clk       (clk),
    .rst       (rst),
    .cyc_go    (en && cyc_start),
    .bank_sel  (bank_sel),
    .one_bank  (one_bank),
    .bank_next (bank_next),
    .act_bank  (active_bank)
  );

  gse_sequencer #(
    .MASK_W (MASK_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .MIN_CNT(MIN_CNT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cyc_start (cyc_start),
    .unit_tick (unit_tick),
    .bank_next (bank_next),
    .act_bank  (active_bank),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .mask      (gate_mask),
    .err_count (err_count),
    .err_addr  (err_addr)
  );
endmodule

// File: tb/gate_sched_engine_tb.sv
module gate_sched_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 1'b0, port_en = 1'b0, link_gig = 1'b1;
  logic        byte_tick = 1'b0, nib_tick = 1'b0, cyc_start = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [6:0]  host_wr_addr = '0;
  logic [21:0] host_wr_data = '0;
  logic        bank_sel = 1'b0, one_bank = 1'b0;
  logic [7:0]  gate_mask;
  logic        active_bank, err_count, err_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_sched_engine u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .port_en(port_en),
    .link_gig(link_gig), .byte_tick(byte_tick), .nib_tick(nib_tick),
    .cyc_start(cyc_start), .host_wr_en(host_wr_en),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .bank_sel(bank_sel), .one_bank(one_bank), .gate_mask(gate_mask),
    .active_bank(active_bank), .err_count(err_count), .err_addr(err_addr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int eff_dur(input int d);
    if (d == 0) return 0;
    if (d < 16) return 16;
    return d;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cmd(input bit bank, input int idx, input logic [7:0] m, input int dur);
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_addr = {bank, 6'(idx)};
    host_wr_data = {14'(dur), m};
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic start_cycle();
    @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    idle(3);
  endtask

  task automatic ticks(input int n, input bit wrong);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (link_gig ^ wrong) byte_tick = 1'b1; else nib_tick = 1'b1;
      @(negedge clk);
      byte_tick = 1'b0;
      nib_tick  = 1'b0;
    end
    idle(3);
  endtask

  logic [7:0] mk [64];
  int         du [64];

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R12 reset state
    chk(gate_mask, 8'hFF, "R12 mask");
    chk(active_bank, 0, "R12 bank");
    chk({err_count, err_addr}, 0, "R12 errs");

    // R1 program bank 0: A/20, B/5, terminator C
    wr_cmd(0, 0, 8'h11, 20);
    wr_cmd(0, 1, 8'h22, 5);
    wr_cmd(0, 2, 8'h3C, 0);
    glb_en = 1'b1; port_en = 1'b1;
    idle(2);
    chk(gate_mask, 8'hFF, "R9 enabled before first start");
    start_cycle();
    chk(gate_mask, 8'h11, "R2 first command mask");
    ticks(8, 1);
    chk(gate_mask, 8'h11, "R4 wrong-speed ticks ignored");
    ticks(19, 0);
    chk(gate_mask, 8'h11, "R7 before duration ends");
    ticks(1, 0);
    chk(gate_mask, 8'h22, "R7 next command");
    ticks(15, 0);
    chk(gate_mask, 8'h22, "R5 short duration floored to 16");
    ticks(1, 0);
    chk(gate_mask, 8'h3C, "R6 terminator mask");
    ticks(10, 0);
    chk(gate_mask, 8'h3C, "R6 terminator holds");
    chk({err_count, err_addr}, 0, "R11 no error on clean cycle");

    // R3 bank switch at cycle boundary
    wr_cmd(1, 0, 8'hA5, 16);
    wr_cmd(1, 1, 8'h5A, 0);
    bank_sel = 1'b1;
    idle(4);
    chk(active_bank, 0, "R3 no switch before start");
    chk(gate_mask, 8'h3C, "R3 mask unchanged before start");
    start_cycle();
    chk(active_bank, 1, "R3 switch at start");
    chk(gate_mask, 8'hA5, "R3 new bank command 0");

    // R11 start during counting
    link_gig = 1'b0;
    ticks(3, 0);
    start_cycle();
    chk(err_count, 1, "R11 count error set");
    chk(gate_mask, 8'hA5, "R11 restart at command 0");
    ticks(15, 0);
    chk(gate_mask, 8'hA5, "R11 full duration after restart");
    ticks(1, 0);
    chk(gate_mask, 8'h5A, "R4 nibble ticks counted");

    // R8 one-bank mode
    one_bank = 1'b1;
    bank_sel = 1'b0;
    start_cycle();
    chk(active_bank, 1, "R8 bank held");
    chk(gate_mask, 8'hA5, "R8 restart in held bank");
    one_bank = 1'b0;
    start_cycle();
    chk(active_bank, 0, "R3 pending select applied");
    chk(gate_mask, 8'h11, "R3 bank 0 command 0");

    // R9 disable clears and opens gates
    port_en = 1'b0;
    idle(2);
    chk(gate_mask, 8'hFF, "R9 disabled mask");
    chk(err_count, 0, "R9 flags cleared");
    start_cycle();
    chk(gate_mask, 8'hFF, "R9 start ignored while disabled");
    chk(active_bank, 0, "R9 bank held while disabled");
    port_en = 1'b1;
    glb_en  = 1'b0;
    start_cycle();
    chk(gate_mask, 8'hFF, "R9 global enable required");
    glb_en = 1'b1;

    // R10 full bank, random masks and durations
    void'($urandom(32'h1234));
    for (int i = 0; i < 64; i++) begin
      mk[i] = 8'($urandom);
      du[i] = 1 + ($urandom % 20);
      wr_cmd(0, i, mk[i], du[i]);
    end
    link_gig = 1'b1;
    start_cycle();
    for (int i = 0; i < 64; i++) begin
      chk(gate_mask, mk[i], "R7 full-bank walk");
      ticks(eff_dur(du[i]), 0);
    end
    chk(err_addr, 1, "R10 address error");
    chk(gate_mask, mk[63], "R10 last mask held");
    ticks(5, 0);
    chk(gate_mask, mk[63], "R10 still held");

    // random schedules on alternating banks
    for (int it = 0; it < 8; it++) begin
      automatic bit b = it[0] ? 1'b0 : 1'b1;
      automatic int n = 1 + ($urandom % 5);
      for (int i = 0; i < n; i++) begin
        mk[i] = 8'($urandom);
        du[i] = 1 + ($urandom % 40);
        wr_cmd(b, i, mk[i], du[i]);
      end
      mk[n] = 8'($urandom);
      wr_cmd(b, n, mk[n], 0);
      link_gig = $urandom % 2;
      bank_sel = b;
      start_cycle();
      chk(active_bank, b, "R3 random bank");
      ticks(4, 1);
      chk(gate_mask, mk[0], "R4 random wrong ticks");
      for (int i = 0; i < n; i++) begin
        chk(gate_mask, mk[i], "R7 random command");
        ticks(eff_dur(du[i]) - 1, 0);
        chk(gate_mask, mk[i], "R5 random before end");
        ticks(1, 0);
      end
      chk(gate_mask, mk[n], "R6 random terminator");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule